// File: doc/BRIEF.md
# IR Wake-Up Frame Matcher

This block watches a consumer-infrared receive path while the rest of the system sleeps. It takes a stream of already demodulated, cell-level bits together with an end-of-message strobe, shifts the bits of each frame into an 88-bit received string, and at the end of the frame compares that string with a pattern loaded by software. Only the bits selected by a second, mask pattern take part in the comparison. In the RC6 protocol, a programmable length also limits the comparison to the most recently received bits.

Software programs the block through a small byte-wide register file. It holds a control byte, a write-one-to-clear status byte, an event-enable byte, an index byte, a data window, a compare-length byte and a cell-time byte. The compare pattern and the mask pattern are 11 bytes each. They are not mapped directly. Software selects an array and a starting byte through the index register and then streams bytes through the data window. Each byte written moves the pointer on by one. When an enabled event flag is set, the block raises its wake output. The output stays high until software clears the flag.

Top module: `irwake_top`

## Requirements
- R1: After reset, every register reads 0x00 except the cell-time register (offset 6), which reads 0x4A, and wakeOut is 0.
- R2: The index register (offset 3) holds a selector in bits 5:4 (01 = compare array, 10 = mask array) and a byte pointer in bits 3:0. A written pointer above 10 becomes 0. Each write to the data window (offset 4) stores the byte at the pointer and advances it, wrapping from 10 to 0. Reads of the data window return the selected byte without advancing. With selector 00 or 11, data writes change nothing and reads return 0.
- R3: Control register (offset 0) bit 0 enables reception. Each rxBitValid cycle shifts rxBit, XORed with control bit 3 (invert), into bit 0 of the received string, so byte k of the string holds received bits 8k+7..8k with the newest bit in bit 0. While bit 0 is clear, bits and rxEnd are ignored.
- R4: On an accepted rxEnd, the status end flag (status bit 1) is set one cycle later. The match flag (status bit 0) is also set if every bit whose mask bit is 1 equals the compare bit. The received string and its bit count then restart empty.
- R5: With control bits 5:4 = 2 (RC6), only string bit positions below the compare-length register (offset 5) take part in the comparison. With 0 (RC5) or 1 (NEC), all 88 positions can take part.
- R6: The buffer flag (status bit 2) is set when the 88th bit of a frame arrives.
- R7: In NEC mode (control bits 5:4 = 1), a frame that ends with fewer than 8 bits sets the repeat flag (status bit 4) and never sets the match flag.
- R8: Writing status (offset 1) clears each flag whose written bit is 1 and leaves the others. A flag set in the same cycle stays set.
- R9: wakeOut is high exactly when an event flag is set and enabled: event-enable (offset 2) bit 0 for match, bit 1 for end, bit 2 for buffer.
- R10: Bits 6:0 of the cell-time register are held and read back, and bit 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset for reads and writes |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| rxBitValid | input | 1 | A received cell bit is present this cycle |
| rxBit | input | 1 | Received cell bit value |
| rxEnd | input | 1 | End of the current message |
| wakeOut | output | 1 | Wake request |

## Verification
The assertions assume that rxEnd and rxBitValid are never high in the same cycle, because a bit arriving on the end strobe is dropped. The stimulus always ends a frame in a cycle of its own, after the last bit. The checks on status clearing assume that software does not clear a flag in a cycle where the receive path may set it. Every status write in the bench is issued while no frame is being received. Register writes and receive bits are driven on separate cycles, so the flag-update cycle is never ambiguous.

// File: rtl/irwake_pkg.sv
package irwake_pkg;
  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_STATUS = 1;
  localparam int unsigned REG_EVEN   = 2;
  localparam int unsigned REG_INDEX  = 3;
  localparam int unsigned REG_DATA   = 4;
  localparam int unsigned REG_CLEN   = 5;
  localparam int unsigned REG_CELL   = 6;

  typedef enum logic [1:0] {
    PROTO_RC5 = 2'd0,
    PROTO_NEC = 2'd1,
    PROTO_RC6 = 2'd2,
    PROTO_RSV = 2'd3
  } proto_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_BAD  = 2'd3
  } arrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrCmp;
    logic       wrMask;
    logic       rdMask;
    logic [3:0] ptr;
    logic [7:0] byteVal;
    logic       shiftEn;
    logic       shiftBit;
    logic       clearFrame;
  } dpStrobe_t;
endpackage

// File: rtl/irwake_dp.sv
module irwake_dp
  import irwake_pkg::*;
#(
  parameter int unsigned BYTES = 11
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobe_t                    strobe,
  input  logic                         useLen,
  input  logic [7:0]                   cmpLen,
  output logic                         matchNow,
  output logic [$clog2(BYTES*8+1)-1:0] bitCount,
  output logic [7:0]                   arrRdByte
);
  localparam int unsigned BITS  = BYTES * 8;
  localparam int unsigned CNT_W = $clog2(BITS + 1);

  logic [BYTES-1:0][7:0] cmpArr;
  logic [BYTES-1:0][7:0] maskArr;
  logic [BITS-1:0]       rxStr;
  logic [CNT_W-1:0]      cnt;
  logic [BITS-1:0]       effMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpArr  <= '0;
      maskArr <= '0;
    end else begin
      if (strobe.wrCmp)  cmpArr[strobe.ptr]  <= strobe.byteVal;
      if (strobe.wrMask) maskArr[strobe.ptr] <= strobe.byteVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxStr <= '0;
      cnt   <= '0;
    end else if (strobe.clearFrame) begin
      rxStr <= '0;
      cnt   <= '0;
    end else if (strobe.shiftEn) begin
      rxStr <= {rxStr[BITS-2:0], strobe.shiftBit};
      if (cnt < CNT_W'(BITS)) cnt <= cnt + 1'b1;
    end
  end

  // per-bit participation: mask bit, limited by length in length mode
  for (genvar gi = 0; gi < BITS; gi++) begin : g_eff
    assign effMask[gi] = maskArr[gi/8][gi%8] & (!useLen || (gi < int'(cmpLen)));
  end

  assign matchNow  = ~|((rxStr ^ cmpArr) & effMask);
  assign bitCount  = cnt;
  assign arrRdByte = strobe.rdMask ? maskArr[strobe.ptr] : cmpArr[strobe.ptr];
endmodule

// File: rtl/irwake_ctrl.sv
module irwake_ctrl
  import irwake_pkg::*;
#(
  parameter int unsigned BYTES  = 11,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWr,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [7:0]                   regWrData,
  output logic [7:0]                   regRdData,
  input  logic                         rxBitValid,
  input  logic                         rxBit,
  input  logic                         rxEnd,
  input  logic                         matchNow,
  input  logic [$clog2(BYTES*8+1)-1:0] bitCount,
  input  logic [7:0]                   arrRdByte,
  output dpStrobe_t                    strobe,
  output logic                         useLen,
  output logic [7:0]                   cmpLen,
  output logic                         rxOn,
  output logic [3:0]                   statusFlags,
  output logic [2:0]                   evEn,
  output logic [3:0]                   idxPtr,
  output logic                         wakeOut
);
  localparam int unsigned BITS  = BYTES * 8;
  localparam int unsigned CNT_W = $clog2(BITS + 1);
  localparam logic [3:0]  LAST  = 4'(BYTES - 1);

  logic [7:0] ctrlReg;
  logic [6:0] cellReg;
  arrSel_e    idxSel;
  logic [3:0] ptrQ;
  logic [3:0] flagQ;   // [0] match [1] end [2] buffer [3] repeat
  logic [2:0] enQ;
  logic [7:0] lenQ;

  proto_e proto;
  logic   wrHit [0:6];
  logic   frameEnd, bitEvt, isRepeat;
  logic   dataWr;
  logic [3:0] setV, clrV;

  assign proto = proto_e'(ctrlReg[5:4]);
  assign rxOn  = ctrlReg[0];

  for (genvar ga = 0; ga < 7; ga++) begin : g_dec
    assign wrHit[ga] = regWr && (regAddr == ADDR_W'(ga));
  end

  assign frameEnd = rxOn && rxEnd;
  assign bitEvt   = rxOn && rxBitValid && !rxEnd;
  assign isRepeat = (proto == PROTO_NEC) && (bitCount < CNT_W'(8));
  assign dataWr   = wrHit[REG_DATA] && (idxSel == SEL_CMP || idxSel == SEL_MASK);

  always_comb begin
    setV    = '0;
    setV[0] = frameEnd && !isRepeat && matchNow;
    setV[1] = frameEnd;
    setV[2] = bitEvt && (bitCount == CNT_W'(BITS - 1));
    setV[3] = frameEnd && isRepeat;
    clrV    = '0;
    if (wrHit[REG_STATUS]) clrV = {regWrData[4], regWrData[2:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      cellReg <= 7'h4A;
      idxSel  <= SEL_NONE;
      ptrQ    <= '0;
      flagQ   <= '0;
      enQ     <= '0;
      lenQ    <= '0;
    end else begin
      if (wrHit[REG_CTRL]) ctrlReg <= regWrData;
      if (wrHit[REG_EVEN]) enQ     <= regWrData[2:0];
      if (wrHit[REG_CLEN]) lenQ    <= regWrData;
      if (wrHit[REG_CELL]) cellReg <= regWrData[6:0];
      if (wrHit[REG_INDEX]) begin
        idxSel <= arrSel_e'(regWrData[5:4]);
        ptrQ   <= (regWrData[3:0] > LAST) ? 4'd0 : regWrData[3:0];
      end else if (dataWr) begin
        ptrQ <= (ptrQ == LAST) ? 4'd0 : ptrQ + 4'd1;
      end
      flagQ <= (flagQ & ~clrV) | setV;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.wrCmp      = dataWr && (idxSel == SEL_CMP);
    strobe.wrMask     = dataWr && (idxSel == SEL_MASK);
    strobe.rdMask     = (idxSel == SEL_MASK);
    strobe.ptr        = ptrQ;
    strobe.byteVal    = regWrData;
    strobe.shiftEn    = bitEvt;
    strobe.shiftBit   = rxBit ^ ctrlReg[3];
    strobe.clearFrame = frameEnd;
  end

  always_comb begin
    unique case (int'(regAddr))
      REG_CTRL:   regRdData = ctrlReg;
      REG_STATUS: regRdData = {3'b000, flagQ[3], 1'b0, flagQ[2:0]};
      REG_EVEN:   regRdData = {5'b00000, enQ};
      REG_INDEX:  regRdData = {2'b00, idxSel, ptrQ};
      REG_DATA:   regRdData = (idxSel == SEL_CMP || idxSel == SEL_MASK) ? arrRdByte : 8'h00;
      REG_CLEN:   regRdData = lenQ;
      REG_CELL:   regRdData = {1'b0, cellReg};
      default:    regRdData = 8'h00;
    endcase
  end

  assign useLen      = (proto == PROTO_RC6);
  assign cmpLen      = lenQ;
  assign statusFlags = flagQ;
  assign evEn        = enQ;
  assign idxPtr      = ptrQ;
  assign wakeOut     = |(flagQ[2:0] & enQ);
endmodule

// File: rtl/irwake_top.sv
module irwake_top
  import irwake_pkg::*;
#(
  parameter int unsigned BYTES  = 11,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              rxBitValid,
  input  logic              rxBit,
  input  logic              rxEnd,
  output logic              wakeOut
);
  localparam int unsigned CNT_W = $clog2(BYTES * 8 + 1);

  dpStrobe_t        strobe;
  logic             useLen;
  logic [7:0]       cmpLen;
  logic             matchNow;
  logic [CNT_W-1:0] bitCount;
  logic [7:0]       arrRdByte;
  logic             rxOn;
  logic [3:0]       statusFlags;
  logic [2:0]       evEn;
  logic [3:0]       idxPtr;

  irwake_ctrl #(.BYTES(BYTES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .rxBitValid(rxBitValid), .rxBit(rxBit), .rxEnd(rxEnd),
    .matchNow(matchNow), .bitCount(bitCount), .arrRdByte(arrRdByte),
    .strobe(strobe), .useLen(useLen), .cmpLen(cmpLen),
    .rxOn(rxOn), .statusFlags(statusFlags), .evEn(evEn), .idxPtr(idxPtr),
    .wakeOut(wakeOut)
  );

  irwake_dp #(.BYTES(BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .useLen(useLen), .cmpLen(cmpLen),
    .matchNow(matchNow), .bitCount(bitCount), .arrRdByte(arrRdByte)
  );
endmodule

// File: rtl/irwake_chk.sv
module irwake_chk #(
  parameter int unsigned BYTES  = 11,
  parameter int unsigned ADDR_W = 3
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         regWr,
  input logic [ADDR_W-1:0]            regAddr,
  input logic [7:0]                   regWrData,
  input logic                         rxEnd,
  input logic                         wakeOut,
  input logic                         rxOn,
  input logic [3:0]                   statusFlags,
  input logic [2:0]                   evEn,
  input logic [$clog2(BYTES*8+1)-1:0] bitCount,
  input logic [3:0]                   idxPtr
);
  localparam int unsigned BITS = BYTES * 8;

  // R2: pointer never leaves the array
  a_r2_ptr_in_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(idxPtr) < BYTES);

  // R3: with reception off the frame count does not move
  a_r3_off_holds_count: assert property (@(posedge clk) disable iff (!rstN)
    !rxOn |=> $stable(bitCount));

  // R4: an accepted end sets the end flag and empties the frame
  a_r4_end_flag: assert property (@(posedge clk) disable iff (!rstN)
    (rxOn && rxEnd) |=> (statusFlags[1] && bitCount == '0));

  // R6: bit count saturates at the string length
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(bitCount) <= BITS);

  // R8: a write of 1 clears the match flag when no end arrives
  a_r8_w1c_match: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_W'(1) && regWrData[0] && !rxEnd) |=> !statusFlags[0]);

  // R9: no enabled event means no wake
  a_r9_no_enable_no_wake: assert property (@(posedge clk) disable iff (!rstN)
    (evEn == 3'b000) |-> !wakeOut);
endmodule

bind irwake_top irwake_chk #(.BYTES(BYTES), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
  .rxEnd(rxEnd), .wakeOut(wakeOut), .rxOn(rxOn), .statusFlags(statusFlags),
  .evEn(evEn), .bitCount(bitCount), .idxPtr(idxPtr)
);

// File: tb/test_irwake_top.sv
`timescale 1ns/1ps
module test_irwake_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       rxBitValid = 1'b0;
  logic       rxBit = 1'b0;
  logic       rxEnd = 1'b0;
  logic       wakeOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irwake_top i_irwake_top (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .rxBitValid(rxBitValid), .rxBit(rxBit), .rxEnd(rxEnd), .wakeOut(wakeOut)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic sendBits(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      rxBitValid = 1'b1; rxBit = v[i];
    end
    @(negedge clk);
    rxBitValid = 1'b0;
  endtask

  task automatic endFrame();
    @(negedge clk);
    rxEnd = 1'b1;
    @(negedge clk);
    rxEnd = 1'b0;
  endtask

  task automatic clearAll();
    wr(3'd1, 8'h17);
  endtask

  task automatic loadArr(input logic [7:0] idx, input logic [7:0] b);
    wr(3'd3, idx);
    wr(3'd4, b);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", d, 8'h00);
    end
    rd(3'd6, d);
    chk("R1 cell-time reset", d, 8'h4A);
    chk("R1 wake at reset", {7'b0, wakeOut}, 8'h00);
  endtask

  task automatic t_array();
    logic [7:0] d;
    wr(3'd3, 8'h10);
    for (int i = 0; i < 11; i++) wr(3'd4, 8'(8'h30 + i));
    wr(3'd3, 8'h13);
    rd(3'd4, d);
    chk("R2 compare byte 3", d, 8'h33);
    rd(3'd3, d);
    chk("R2 index readback", d, 8'h13);
    wr(3'd3, 8'h29);
    wr(3'd4, 8'hA9); wr(3'd4, 8'hAA); wr(3'd4, 8'hAB);
    rd(3'd3, d);
    chk("R2 pointer wrapped", d, 8'h21);
    wr(3'd3, 8'h20);
    rd(3'd4, d);
    chk("R2 mask wrap byte 0", d, 8'hAB);
    wr(3'd3, 8'h2A);
    rd(3'd4, d);
    chk("R2 mask byte 10", d, 8'hAA);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'hEE);
    rd(3'd4, d);
    chk("R2 no-select read", d, 8'h00);
    wr(3'd3, 8'h10);
    rd(3'd4, d);
    chk("R2 no-select write ignored", d, 8'h30);
    wr(3'd3, 8'h1F);
    rd(3'd3, d);
    chk("R2 pointer clamp", d, 8'h10);
    // restore: mask all zero, compare all zero
    wr(3'd3, 8'h20);
    for (int i = 0; i < 11; i++) wr(3'd4, 8'h00);
    wr(3'd3, 8'h10);
    for (int i = 0; i < 11; i++) wr(3'd4, 8'h00);
  endtask

  task automatic t_match();
    logic [7:0] d;
    loadArr(8'h10, 8'hA5);
    loadArr(8'h20, 8'hFF);
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h01);
    sendBits(8'hA5, 8);
    endFrame();
    rd(3'd1, d);
    chk("R4 match and end", d, 8'h03);
    chk("R9 wake on match", {7'b0, wakeOut}, 8'h01);
    clearAll();
    rd(3'd1, d);
    chk("R8 cleared", d, 8'h00);
    chk("R9 wake low after clear", {7'b0, wakeOut}, 8'h00);
    sendBits(8'hA4, 8);
    endFrame();
    rd(3'd1, d);
    chk("R4 mismatch end only", d, 8'h02);
    chk("R9 end not enabled", {7'b0, wakeOut}, 8'h00);
    wr(3'd2, 8'h02);
    chk("R9 end enabled", {7'b0, wakeOut}, 8'h01);
    wr(3'd2, 8'h00);
    clearAll();
    loadArr(8'h20, 8'hF0);
    sendBits(8'hAF, 8);
    endFrame();
    rd(3'd1, d);
    chk("R4 don't-care low nibble", d, 8'h03);
    clearAll();
    loadArr(8'h20, 8'hFF);
    wr(3'd0, 8'h09);
    sendBits(8'h5A, 8);
    endFrame();
    rd(3'd1, d);
    chk("R3 inverted input match", d, 8'h03);
    clearAll();
    wr(3'd0, 8'h01);
    sendBits(8'hA5, 8);
    sendBits(8'h00, 4);
    endFrame();
    rd(3'd1, d);
    chk("R3 newest bit at bit 0", d, 8'h02);
    clearAll();
  endtask

  task automatic t_partial_clear();
    logic [7:0] d;
    sendBits(8'hA5, 8);
    endFrame();
    wr(3'd1, 8'h02);
    rd(3'd1, d);
    chk("R8 partial clear keeps match", d, 8'h01);
    clearAll();
  endtask

  task automatic t_rc6();
    logic [7:0] d;
    loadArr(8'h10, 8'h05);
    wr(3'd0, 8'h21);
    wr(3'd5, 8'd4);
    sendBits(8'hF5, 8);
    endFrame();
    rd(3'd1, d);
    chk("R5 length 4 match", d, 8'h03);
    clearAll();
    wr(3'd5, 8'd8);
    sendBits(8'hF5, 8);
    endFrame();
    rd(3'd1, d);
    chk("R5 length 8 mismatch", d, 8'h02);
    clearAll();
    wr(3'd0, 8'h01);
    wr(3'd5, 8'd4);
    sendBits(8'hF5, 8);
    endFrame();
    rd(3'd1, d);
    chk("R5 length unused in RC5", d, 8'h02);
    clearAll();
  endtask

  task automatic t_nec();
    logic [7:0] d;
    loadArr(8'h20, 8'h00);
    wr(3'd0, 8'h11);
    wr(3'd2, 8'h01);
    sendBits(8'h05, 3);
    endFrame();
    rd(3'd1, d);
    chk("R7 repeat frame", d, 8'h12);
    chk("R7 no wake on repeat", {7'b0, wakeOut}, 8'h00);
    clearAll();
    sendBits(8'h3C, 8);
    endFrame();
    rd(3'd1, d);
    chk("R7 full NEC frame matches", d, 8'h03);
    clearAll();
  endtask

  task automatic t_buffer();
    logic [7:0] d;
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h04);
    sendBits(8'hFF, 8);
    for (int b = 0; b < 9; b++) sendBits(8'h00, 8);
    sendBits(8'h00, 7);
    rd(3'd1, d);
    chk("R6 87 bits no buffer", d, 8'h00);
    sendBits(8'h01, 1);
    rd(3'd1, d);
    chk("R6 88th bit buffer", d, 8'h04);
    chk("R9 wake on buffer", {7'b0, wakeOut}, 8'h01);
    endFrame();
    clearAll();
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h07);
    sendBits(8'hA5, 8);
    endFrame();
    rd(3'd1, d);
    chk("R3 disabled ignores frame", d, 8'h00);
    chk("R3 disabled no wake", {7'b0, wakeOut}, 8'h00);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_cell();
    logic [7:0] d;
    wr(3'd6, 8'hFF);
    rd(3'd6, d);
    chk("R10 cell-time bit 7 reads 0", d, 8'h7F);
    wr(3'd6, 8'h12);
    rd(3'd6, d);
    chk("R10 cell-time readback", d, 8'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_array();
    t_match();
    t_partial_clear();
    t_rc6();
    t_nec();
    t_buffer();
    t_disabled();
    t_cell();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule